// File: doc/BRIEF.md
# Special-Register Access Unit

This block sits beside a small 32-bit core and serves its move-to and move-from special-register instructions. A write request carries a 16-bit register number and a 32-bit value. The unit decodes the number and updates the selected register. Each register follows its own write rule: the interrupt mask can only gain bits, the interrupt pending set clears the bits written as one, and the 64-bit accumulator is written one half at a time. Some writes also cause an action in the rest of the core. These actions come out as one-cycle pulses: a translation-buffer flush, a program-counter redirect and a halt request.

A read request returns the value of the addressed register combinationally. If the address maps to nothing readable, the read returns a fallback word supplied by the caller, so the core's destination register keeps its old contents. The core's current program counter and a hardware interrupt-raise vector come in as inputs. The live interrupt mask and pending bits go out for the interrupt logic.

Top module: `spr_access_unit`

## Requirements
- R1: A register number is the group shifted left by 11 plus the index within the group. Writes take effect at the rising clock edge and are visible to a combinational read in the next cycle. A synchronous active-low reset clears every storage register to zero.
- R2: A write to group 9 index 0 (interrupt mask) ORs the data into the mask. A mask bit never returns to zero except through reset.
- R3: A write to group 9 index 2 (interrupt pending) clears each pending bit whose data bit is 1 and leaves the other bits unchanged. Each `irq_raise` bit sets its pending bit, and a raise wins over a clear of the same bit in the same cycle.
- R4: The 64-bit accumulator reads and writes its low word at group 5 index 1 and its high word at group 5 index 2. A write to one half leaves the other half unchanged.
- R5: A read of group 0 index 128 returns 0 and a read of group 0 index 129 returns 1. Writes to these numbers have no effect.
- R6: A read of an unmapped number, or any read with `rd_valid` low, returns `rd_fallback`. A write to an unmapped number changes no register.
- R7: A write to group 0 index 17 (status) stores the data. `tlb_flush` pulses when bit 0 (supervisor), bit 5 (data translation enable) or bit 6 (instruction translation enable) differs from the stored value.
- R8: A write to group 0 index 16 (next PC) with data different from `cur_pc` pulses `pc_redirect` and `dslot_kill`, and `redirect_pc` holds the data. A write equal to `cur_pc` does nothing. A read of this number returns `cur_pc`.
- R9: A write to group 8 index 0 (power management) stores the data. If bit 4 (doze) or bit 5 (sleep) is set, the write pulses `halt_req`, and `halt_pc` holds `cur_pc + 4`.
- R10: `tlb_flush`, `pc_redirect` and `halt_req` are high only in the cycle right after the write that triggers them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write request strobe |
| wr_addr | input | 16 | Register number of the write |
| wr_data | input | 32 | Write value |
| rd_valid | input | 1 | Read request strobe |
| rd_addr | input | 16 | Register number of the read |
| rd_fallback | input | 32 | Value returned when nothing is read |
| rd_data | output | 32 | Read result |
| cur_pc | input | 32 | Core's current program counter |
| irq_raise | input | 32 | Hardware interrupt set vector |
| tlb_flush | output | 1 | Translation flush pulse |
| pc_redirect | output | 1 | Program-counter redirect pulse |
| dslot_kill | output | 1 | Delay-slot flag clear pulse |
| redirect_pc | output | 32 | Redirect target |
| halt_req | output | 1 | Halt request pulse |
| halt_pc | output | 32 | Resume address after halt |
| irq_mask | output | 32 | Current interrupt mask |
| irq_pend | output | 32 | Current interrupt pending bits |

## Verification
Two cases are hard to reach from the ports: a hardware raise and a software clear that hit the same pending bit in the same cycle, and a status write whose flush depends on the exact value already stored. The stimulus first loads a known pending pattern through `irq_raise`. It then drives a clear together with a raise on one chosen bit. It also walks the status register through a sequence of writes in which each write changes one watched bit, or changes only an unwatched bit. That way every flush pulse, and every missing one, can be traced to one bit.

// File: rtl/spr_pkg.sv
// Package: shared selector type for the special-register access unit.
// Assumes: one selector value per implemented register number.
package spr_pkg;
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_NPC,
        SEL_STATUS,
        SEL_COREID,
        SEL_NCORES,
        SEL_ACC_LO,
        SEL_ACC_HI,
        SEL_PWR,
        SEL_MASK,
        SEL_PEND
    } spr_sel_e;
endpackage

// File: rtl/spr_addr_decode.sv
// Module: spr_addr_decode
// Maps a register number (group << GRP_SHIFT plus index) to a selector.
// Assumes: numbers outside the implemented set map to SEL_NONE.
module spr_addr_decode
    import spr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int GRP_SHIFT = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output spr_sel_e          sel
);
    function automatic logic [ADDR_W-1:0] num(input int grp, input int idx);
        return ADDR_W'((grp << GRP_SHIFT) + idx);
    endfunction

    localparam logic [ADDR_W-1:0] N_NPC    = num(0, 16);
    localparam logic [ADDR_W-1:0] N_STATUS = num(0, 17);
    localparam logic [ADDR_W-1:0] N_COREID = num(0, 128);
    localparam logic [ADDR_W-1:0] N_NCORES = num(0, 129);
    localparam logic [ADDR_W-1:0] N_ACC_LO = num(5, 1);
    localparam logic [ADDR_W-1:0] N_ACC_HI = num(5, 2);
    localparam logic [ADDR_W-1:0] N_PWR    = num(8, 0);
    localparam logic [ADDR_W-1:0] N_MASK   = num(9, 0);
    localparam logic [ADDR_W-1:0] N_PEND   = num(9, 2);

    // Compare the number against each implemented register.
    always_comb begin
        case (addr)
            N_NPC:    sel = SEL_NPC;
            N_STATUS: sel = SEL_STATUS;
            N_COREID: sel = SEL_COREID;
            N_NCORES: sel = SEL_NCORES;
            N_ACC_LO: sel = SEL_ACC_LO;
            N_ACC_HI: sel = SEL_ACC_HI;
            N_PWR:    sel = SEL_PWR;
            N_MASK:   sel = SEL_MASK;
            N_PEND:   sel = SEL_PEND;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/spr_state_regs.sv
// Module: spr_state_regs
// Holds the writable registers and applies each register's write rule.
// Assumes: wr_en is already qualified by the request strobe.
module spr_state_regs
    import spr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  spr_sel_e            wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W-1:0]   irq_raise,
    output logic [DATA_W-1:0]   status_q,
    output logic [DATA_W-1:0]   mask_q,
    output logic [DATA_W-1:0]   pend_q,
    output logic [2*DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0]   pwr_q
);
    logic [DATA_W-1:0] pend_clr;

    // Pending clear vector: the written ones, only for a pending write.
    assign pend_clr = (wr_en && wr_sel == SEL_PEND) ? wr_data : '0;

    // Status and power registers: plain replace.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            pwr_q    <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_STATUS) status_q <= wr_data;
            if (wr_sel == SEL_PWR)    pwr_q    <= wr_data;
        end
    end

    // Interrupt mask: bits can only be added.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mask_q <= '0;
        else if (wr_en && wr_sel == SEL_MASK) mask_q <= mask_q | wr_data;
    end

    // Interrupt pending: write-one-to-clear, hardware raise wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | irq_raise;
    end

    // Accumulator: each write deposits one 32-bit half.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else if (wr_en) begin
            if (wr_sel == SEL_ACC_LO) acc_q[DATA_W-1:0]        <= wr_data;
            if (wr_sel == SEL_ACC_HI) acc_q[2*DATA_W-1:DATA_W] <= wr_data;
        end
    end

    // R2: no mask bit ever falls outside reset.
    a_r2_mask_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mask_q) & ~mask_q) == '0));

    // R3: bits written as one are clear unless raised in the same cycle.
    a_r3_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_sel == SEL_PEND) |->
        ((pend_q & $past(wr_data) & ~$past(irq_raise)) == '0));

    // R4: a low-half write keeps the high half.
    a_r4_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_sel == SEL_ACC_LO) |->
        (acc_q[2*DATA_W-1:DATA_W] == $past(acc_q[2*DATA_W-1:DATA_W])));

    // R4: a high-half write keeps the low half.
    a_r4_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_sel == SEL_ACC_HI) |->
        (acc_q[DATA_W-1:0] == $past(acc_q[DATA_W-1:0])));
endmodule

// File: rtl/spr_side_effects.sv
// Module: spr_side_effects
// Turns writes into registered one-cycle action pulses.
// Assumes: status_q is the value held before the current write.
module spr_side_effects
    import spr_pkg::*;
#(
    parameter int                 DATA_W      = 32,
    parameter int                 PC_STEP     = 4,
    parameter logic [DATA_W-1:0]  STATUS_WATCH = 32'h0000_0061,
    parameter logic [DATA_W-1:0]  PWR_HALT     = 32'h0000_0030
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  spr_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] status_q,
    input  logic [DATA_W-1:0] cur_pc,
    output logic              tlb_flush,
    output logic              pc_redirect,
    output logic              dslot_kill,
    output logic [DATA_W-1:0] redirect_pc,
    output logic              halt_req,
    output logic [DATA_W-1:0] halt_pc
);
    logic flush_hit, redir_hit, halt_hit;

    // Trigger conditions for each action.
    always_comb begin
        flush_hit = wr_en && wr_sel == SEL_STATUS &&
                    (((status_q ^ wr_data) & STATUS_WATCH) != '0);
        redir_hit = wr_en && wr_sel == SEL_NPC && (wr_data != cur_pc);
        halt_hit  = wr_en && wr_sel == SEL_PWR && ((wr_data & PWR_HALT) != '0);
    end

    // Register the pulses and their attached addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tlb_flush   <= 1'b0;
            pc_redirect <= 1'b0;
            dslot_kill  <= 1'b0;
            halt_req    <= 1'b0;
            redirect_pc <= '0;
            halt_pc     <= '0;
        end else begin
            tlb_flush   <= flush_hit;
            pc_redirect <= redir_hit;
            dslot_kill  <= redir_hit;
            halt_req    <= halt_hit;
            if (redir_hit) redirect_pc <= wr_data;
            if (halt_hit)  halt_pc     <= cur_pc + DATA_W'(PC_STEP);
        end
    end

    // R7: a flush only follows a status write.
    a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(wr_en && wr_sel == SEL_STATUS));

    // R8: a redirect target never equals the PC it replaced.
    a_r8_redirect_differs: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |-> (redirect_pc != $past(cur_pc)));

    // R9: the halt resume address is the old PC plus one step.
    a_r9_halt_pc: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (halt_pc == $past(cur_pc) + DATA_W'(PC_STEP)));

    // R10: any action pulse follows a write in the previous cycle.
    a_r10_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_flush || pc_redirect || halt_req) |-> $past(wr_en));
endmodule

// File: rtl/spr_access_unit.sv
// Module: spr_access_unit (top)
// Decodes register writes and reads, stores state, raises action pulses.
// Assumes: one write and one read per cycle; reads see committed state.
module spr_access_unit
    import spr_pkg::*;
#(
    parameter int                DATA_W       = 32,
    parameter int                ADDR_W       = 16,
    parameter int                GRP_SHIFT    = 11,
    parameter int                PC_STEP      = 4,
    parameter logic [DATA_W-1:0] STATUS_WATCH = 32'h0000_0061,
    parameter logic [DATA_W-1:0] PWR_HALT     = 32'h0000_0030
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_fallback,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] cur_pc,
    input  logic [DATA_W-1:0] irq_raise,
    output logic              tlb_flush,
    output logic              pc_redirect,
    output logic              dslot_kill,
    output logic [DATA_W-1:0] redirect_pc,
    output logic              halt_req,
    output logic [DATA_W-1:0] halt_pc,
    output logic [DATA_W-1:0] irq_mask,
    output logic [DATA_W-1:0] irq_pend
);
    localparam logic [DATA_W-1:0] CORE_ID    = '0;
    localparam logic [DATA_W-1:0] CORE_COUNT = DATA_W'(1);

    spr_sel_e            wsel, rsel;
    logic [DATA_W-1:0]   status_q, pwr_q;
    logic [2*DATA_W-1:0] acc_q;

    spr_addr_decode #(.ADDR_W(ADDR_W), .GRP_SHIFT(GRP_SHIFT)) u_wdec (
        .addr(wr_addr), .sel(wsel));

    spr_addr_decode #(.ADDR_W(ADDR_W), .GRP_SHIFT(GRP_SHIFT)) u_rdec (
        .addr(rd_addr), .sel(rsel));

    spr_state_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_valid), .wr_sel(wsel),
        .wr_data(wr_data), .irq_raise(irq_raise), .status_q(status_q),
        .mask_q(irq_mask), .pend_q(irq_pend), .acc_q(acc_q), .pwr_q(pwr_q));

    spr_side_effects #(
        .DATA_W(DATA_W), .PC_STEP(PC_STEP),
        .STATUS_WATCH(STATUS_WATCH), .PWR_HALT(PWR_HALT)
    ) u_fx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_valid), .wr_sel(wsel),
        .wr_data(wr_data), .status_q(status_q), .cur_pc(cur_pc),
        .tlb_flush(tlb_flush), .pc_redirect(pc_redirect),
        .dslot_kill(dslot_kill), .redirect_pc(redirect_pc),
        .halt_req(halt_req), .halt_pc(halt_pc));

    // Read multiplexer with fallback for idle or unmapped reads.
    always_comb begin
        rd_data = rd_fallback;
        if (rd_valid) begin
            case (rsel)
                SEL_NPC:    rd_data = cur_pc;
                SEL_STATUS: rd_data = status_q;
                SEL_COREID: rd_data = CORE_ID;
                SEL_NCORES: rd_data = CORE_COUNT;
                SEL_ACC_LO: rd_data = acc_q[DATA_W-1:0];
                SEL_ACC_HI: rd_data = acc_q[2*DATA_W-1:DATA_W];
                SEL_PWR:    rd_data = pwr_q;
                SEL_MASK:   rd_data = irq_mask;
                SEL_PEND:   rd_data = irq_pend;
                default:    rd_data = rd_fallback;
            endcase
        end
    end

    // R6: an idle read port always returns the fallback.
    a_r6_idle_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == rd_fallback));

    // R8: the delay-slot clear travels with every redirect.
    a_r8_kill_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect == dslot_kill);
endmodule

// File: tb/spr_access_unit_tb.sv
module spr_access_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FB = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, rd_valid = 1'b0;
    logic [15:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_fallback = FB, cur_pc = 32'h100, irq_raise = '0;
    logic [31:0] rd_data, redirect_pc, halt_pc, irq_mask, irq_pend;
    logic        tlb_flush, pc_redirect, dslot_kill, halt_req;

    int checks = 0, fails = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_access_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_fallback(rd_fallback), .rd_data(rd_data), .cur_pc(cur_pc),
        .irq_raise(irq_raise), .tlb_flush(tlb_flush), .pc_redirect(pc_redirect),
        .dslot_kill(dslot_kill), .redirect_pc(redirect_pc), .halt_req(halt_req),
        .halt_pc(halt_pc), .irq_mask(irq_mask), .irq_pend(irq_pend));

    localparam logic [15:0] A_NPC = 16'h0010, A_STATUS = 16'h0011,
        A_COREID = 16'h0080, A_NCORES = 16'h0081, A_ACC_LO = 16'h2801,
        A_ACC_HI = 16'h2802, A_PWR = 16'h4000, A_MASK = 16'h4800,
        A_PEND = 16'h4802, A_HOLE = 16'h1234;

    typedef struct packed {
        logic [15:0] wa;
        logic [31:0] wd;
        logic [15:0] ra;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{A_ACC_LO, 32'h1111_1111, A_ACC_LO, 32'h1111_1111}, // R4
        '{A_ACC_HI, 32'h2222_2222, A_ACC_LO, 32'h1111_1111}, // R4
        '{A_ACC_LO, 32'h3333_3333, A_ACC_HI, 32'h2222_2222}, // R4
        '{A_MASK,   32'h0000_00F0, A_MASK,   32'h0000_00F0}, // R2
        '{A_MASK,   32'h0000_0F00, A_MASK,   32'h0000_0FF0}, // R2
        '{A_MASK,   32'h0000_0000, A_MASK,   32'h0000_0FF0}, // R2
        '{A_STATUS, 32'h0000_8000, A_STATUS, 32'h0000_8000}, // R7
        '{A_PWR,    32'h0000_0003, A_PWR,    32'h0000_0003}, // R9
        '{A_HOLE,   32'hFFFF_FFFF, A_HOLE,   FB},            // R6
        '{A_COREID, 32'h0000_0005, A_COREID, 32'h0000_0000}, // R5
        '{A_NCORES, 32'h0000_0007, A_NCORES, 32'h0000_0001}  // R5
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One write cycle; returns at the falling edge after the commit edge.
    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
        rd_valid = 1'b1; rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
        rd_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog R10: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state of every register and pulse.
        read_chk("R1 mask reset", A_MASK, 32'h0);
        read_chk("R1 pend reset", A_PEND, 32'h0);
        read_chk("R1 status reset", A_STATUS, 32'h0);
        read_chk("R1 acc reset", A_ACC_HI, 32'h0);
        read_chk("R1 pwr reset", A_PWR, 32'h0);
        chk("R1 pulses idle", {29'h0, tlb_flush, pc_redirect, halt_req}, 32'h0);

        // Table walk: write, then read back the next cycle (R1).
        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i].wa, VECS[i].wd);
            read_chk($sformatf("R1 table row %0d", i), VECS[i].ra, VECS[i].exp);
            chk($sformatf("R10 no pulse row %0d", i),
                {29'h0, tlb_flush, pc_redirect, halt_req}, 32'h0);
        end

        // R6: idle read port returns the fallback.
        rd_valid = 1'b0; rd_addr = A_MASK; #1;
        chk("R6 idle read", rd_data, FB);

        // R3: raise, clear, and raise beating a clear.
        @(negedge clk); irq_raise = 32'hFF;
        @(negedge clk); irq_raise = '0;
        read_chk("R3 raised", A_PEND, 32'h0000_00FF);
        do_write(A_PEND, 32'h0000_000F);
        read_chk("R3 cleared low", A_PEND, 32'h0000_00F0);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = A_PEND; wr_data = 32'h0000_0011; irq_raise = 32'h0000_0011;
        @(negedge clk);
        wr_valid = 1'b0; irq_raise = '0;
        read_chk("R3 raise wins", A_PEND, 32'h0000_00F1);
        do_write(A_PEND, 32'hFFFF_FFFF);
        read_chk("R3 all cleared", A_PEND, 32'h0);

        // R7: flush on watched status bits only; R10 single-cycle pulse.
        do_write(A_STATUS, 32'h0000_8001);
        chk("R7 flush on supervisor bit", {31'h0, tlb_flush}, 32'h1);
        @(negedge clk);
        chk("R10 flush drops", {31'h0, tlb_flush}, 32'h0);
        do_write(A_STATUS, 32'h0000_8001);
        chk("R7 no flush same value", {31'h0, tlb_flush}, 32'h0);
        do_write(A_STATUS, 32'h0000_8021);
        chk("R7 flush on data xlate bit", {31'h0, tlb_flush}, 32'h1);
        do_write(A_STATUS, 32'h0000_8061);
        chk("R7 flush on instr xlate bit", {31'h0, tlb_flush}, 32'h1);
        do_write(A_STATUS, 32'h0000_8063);
        chk("R7 no flush unwatched bit", {31'h0, tlb_flush}, 32'h0);
        read_chk("R7 status stored", A_STATUS, 32'h0000_8063);

        // R8: redirect on a different PC only.
        do_write(A_NPC, 32'h0000_0200);
        chk("R8 redirect pulse", {30'h0, pc_redirect, dslot_kill}, 32'h3);
        chk("R8 redirect target", redirect_pc, 32'h0000_0200);
        @(negedge clk);
        chk("R10 redirect drops", {31'h0, pc_redirect}, 32'h0);
        do_write(A_NPC, 32'h0000_0100);
        chk("R8 same PC ignored", {30'h0, pc_redirect, dslot_kill}, 32'h0);
        chk("R8 target kept", redirect_pc, 32'h0000_0200);
        read_chk("R8 read returns PC", A_NPC, 32'h0000_0100);

        // R9: doze and sleep bits request a halt.
        do_write(A_PWR, 32'h0000_0010);
        chk("R9 halt on doze", {31'h0, halt_req}, 32'h1);
        chk("R9 resume PC", halt_pc, 32'h0000_0104);
        read_chk("R9 pwr stored", A_PWR, 32'h0000_0010);
        @(negedge clk);
        chk("R10 halt drops", {31'h0, halt_req}, 32'h0);
        cur_pc = 32'h0000_0300;
        do_write(A_PWR, 32'h0000_0020);
        chk("R9 halt on sleep", {31'h0, halt_req}, 32'h1);
        chk("R9 resume PC sleep", halt_pc, 32'h0000_0304);

        // R2: mask output reflects ORed writes and no write cleared it.
        chk("R2 mask port", irq_mask, 32'h0000_0FF0);
        // R6: the unmapped write earlier left the accumulator intact.
        read_chk("R6 acc untouched", A_ACC_LO, 32'h3333_3333);

        finish_run();
    end
endmodule